// File: doc/BRIEF.md
# I2C Multi-Address Slave Status Unit

This unit sits beside an I2C slave and keeps a one-byte status word that the host CPU reads. It samples the SCL and SDA lines through a synchronizer, spots START and STOP conditions, and counts bits. It then compares the first byte after each START against three programmable slave addresses at once. Each address register has its own match flag.

The unit also runs an ACK-phase clock stretch. When enabled, it drops a second hold flag on the SCL falling edge that closes the eighth data bit, and it raises a one-cycle interrupt at that moment. The SCL-hold request is asserted while either the host's primary hold bit or this second flag is low. A STOP-detected flag is latched for the host.

The host side uses write strobes to clear the match flags (by writing the data shift register), to clear the STOP flag, and to release the second hold flag. Control levels select the address format and enable each feature. Data shifting, ACK driving and master operation are handled elsewhere.

Top module: `i2c_addr_status`

## Requirements
- R1: `status` carries the match flags of slots 0, 1 and 2 in bits 0, 1 and 2, the second hold flag in bit 5 (1 = released), and the STOP flag in bit 7. Bits 3, 4 and 6 are always 0. After reset `status` is 8'h20.
- R2: With `ten_bit`=0, match flag i is set after the first byte following a START (bits received MSB first, sampled on SCL rise) when that byte's bits [7:1] equal `slave_addr[i][7:1]`. Every slot that agrees is flagged.
- R3: With `ten_bit`=1, match flag i is set when the whole first byte, R/W bit included, equals `slave_addr[i][7:0]`.
- R4: Only the first byte after a START updates the match flags. The flags read 0 while `match_en`=0, and a `data_wr` strobe clears them.
- R5: When `ack_irq_en`=1 and `ack_clk_en`=1, the second hold flag goes to 0 on the SCL falling edge that ends the 8th data bit. If either bit is 0, that edge leaves the flag at 1.
- R6: The second hold flag returns to 1 on a `hold2_set_wr` strobe, and is held at 1 while `ack_irq_en`=0.
- R7: `scl_hold` is 1 whenever `hold_n`=0 or the second hold flag is 0. It is 0 only when both are 1.
- R8: A STOP (SDA rising while SCL is high) sets the STOP flag whatever `match_en` and `ten_bit` are. The flag clears on a `stop_clr_wr` strobe and reads 0 while `bus_en`=0.
- R9: `irq` is a one-cycle pulse on the same clock where the second hold flag changes from 1 to 0.
- R10: A START (SDA falling while SCL is high) restarts the bit count. After a repeated START, the next byte is compared again as a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| bus_en | input | 1 | Bus interface enable; 0 forces the STOP flag to 0 |
| match_en | input | 1 | Slave address compare enable |
| ten_bit | input | 1 | 0: 7-bit compare, 1: full 8-bit first-byte compare |
| ack_irq_en | input | 1 | Enables the ACK-phase hold and interrupt |
| ack_clk_en | input | 1 | ACK clock present |
| hold_n | input | 1 | Primary hold bit, 0 holds SCL low |
| data_wr | input | 1 | Strobe: host wrote the data shift register |
| stop_clr_wr | input | 1 | Strobe: clear the STOP flag |
| hold2_set_wr | input | 1 | Strobe: release the second hold flag |
| slave_addr | input | 3x8 | Slave address slots; [7:1] address, [0] R/W compare bit |
| status | output | 8 | Status word |
| scl_hold | output | 1 | 1 requests SCL be held low |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the unit with a three-stage synchronizer instead of the default two. This shows that every flag update follows the bus by the synchronizer latency alone, and that no check depends on a fixed pipeline depth. The three slots are loaded with values whose upper seven bits collide on slots 0 and 2 but differ in the R/W bit. A single first byte can therefore hit several slots in 7-bit mode and exactly one in 10-bit mode. Repeated STARTs, a second data byte, and traffic with compare disabled show that only the first byte after a START moves the flags.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;

    localparam int NUM_SLOTS  = 3;
    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = DATA_BITS + 1;
    localparam int STAT_W     = 8;
    localparam int HOLD2_POS  = 5;
    localparam int STOP_POS   = 7;

    typedef logic [DATA_BITS-1:0] byte_t;

    typedef enum logic {
        FMT_7BIT  = 1'b0,
        FMT_10BIT = 1'b1
    } addr_fmt_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } line_ev_t;

    function automatic logic slot_hit(addr_fmt_e fmt, byte_t rx, byte_t slot);
        if (fmt == FMT_10BIT)
            return rx == slot;
        return rx[DATA_BITS-1:1] == slot[DATA_BITS-1:1];
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(
        logic [NUM_SLOTS-1:0] hits, logic hold2, logic stop_seen);
        logic [STAT_W-1:0] s;
        s                = '0;
        s[NUM_SLOTS-1:0] = hits;
        s[HOLD2_POS]     = hold2;
        s[STOP_POS]      = stop_seen;
        return s;
    endfunction

endpackage

// File: rtl/i2cst_line_sync.sv
module i2cst_line_sync
    import i2cst_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;
    logic              sda_now;

    // idle bus is high, so reset to 1 to avoid a false edge
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    assign scl_now = scl_pipe[STAGES-1];
    assign sda_now = sda_pipe[STAGES-1];

    always_comb begin
        ev.sda      = sda_now;
        ev.scl_rise = scl_now & ~scl_prev;
        ev.scl_fall = ~scl_now & scl_prev;
        ev.start    = scl_now & scl_prev & sda_prev & ~sda_now;
        ev.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
    end

    AST_STOP_NEEDS_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> scl_prev); // R8

endmodule

// File: rtl/i2cst_bit_track.sv
module i2cst_bit_track
    import i2cst_pkg::*;
#(
    parameter int CNT_W = $clog2(FRAME_BITS + 1)
) (
    input  logic     clk,
    input  logic     rst,
    input  line_ev_t ev,
    output logic     first_done,
    output byte_t    rx_byte,
    output logic     data_end
);

    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_BITS - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(DATA_BITS);

    logic                 active;
    logic                 first;
    logic [CNT_W-1:0]     cnt;
    logic [DATA_BITS-2:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            first  <= 1'b0;
            cnt    <= '0;
            shreg  <= '0;
        end else if (ev.start) begin
            active <= 1'b1;
            first  <= 1'b1;
            cnt    <= '0;
        end else if (ev.stop) begin
            active <= 1'b0;
            first  <= 1'b0;
            cnt    <= '0;
        end else if (active && ev.scl_rise) begin
            if (cnt == ACK_SLOT) begin
                cnt <= '0;
            end else begin
                shreg <= {shreg[DATA_BITS-3:0], ev.sda};
                cnt   <= cnt + 1'b1;
                if (cnt == LAST_DATA)
                    first <= 1'b0;
            end
        end
    end

    assign rx_byte    = {shreg, ev.sda};
    assign first_done = active & first & ev.scl_rise & (cnt == LAST_DATA);
    assign data_end   = active & ev.scl_fall & (cnt == ACK_SLOT);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= ACK_SLOT); // R10
    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (cnt == '0) && first); // R10

endmodule

// File: rtl/i2cst_addr_match.sv
module i2cst_addr_match
    import i2cst_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      match_en,
    input  addr_fmt_e                 fmt,
    input  logic                      cmp_valid,
    input  byte_t                     rx_byte,
    input  logic                      data_wr,
    input  logic [NUM_SLOTS-1:0][7:0] slots,
    output logic [NUM_SLOTS-1:0]      flags
);

    logic [NUM_SLOTS-1:0] hits;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign hits[i] = slot_hit(fmt, rx_byte, slots[i]);
    end

    // compare result wins over a host clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst || !match_en)
            flags <= '0;
        else if (cmp_valid)
            flags <= hits;
        else if (data_wr)
            flags <= '0;
    end

    AST_MATCH_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !match_en |=> flags == '0); // R4
    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (match_en && !cmp_valid && !data_wr) |=> $stable(flags)); // R4

endmodule

// File: rtl/i2c_addr_status.sv
module i2c_addr_status
    import i2cst_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      scl_in,
    input  logic                      sda_in,
    input  logic                      bus_en,
    input  logic                      match_en,
    input  logic                      ten_bit,
    input  logic                      ack_irq_en,
    input  logic                      ack_clk_en,
    input  logic                      hold_n,
    input  logic                      data_wr,
    input  logic                      stop_clr_wr,
    input  logic                      hold2_set_wr,
    input  logic [NUM_SLOTS-1:0][7:0] slave_addr,
    output logic [STAT_W-1:0]         status,
    output logic                      scl_hold,
    output logic                      irq
);

    line_ev_t             ev;
    logic                 first_done;
    byte_t                rx_byte;
    logic                 data_end;
    logic [NUM_SLOTS-1:0] flags;
    logic                 hold2;
    logic                 stop_seen;

    i2cst_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2cst_bit_track u_track (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .first_done (first_done),
        .rx_byte    (rx_byte),
        .data_end   (data_end)
    );

    i2cst_addr_match u_match (
        .clk       (clk),
        .rst       (rst),
        .match_en  (match_en),
        .fmt       (addr_fmt_e'(ten_bit)),
        .cmp_valid (first_done),
        .rx_byte   (rx_byte),
        .data_wr   (data_wr),
        .slots     (slave_addr),
        .flags     (flags)
    );

    // ACK-phase hold: hardware drop wins over a host release
    always_ff @(posedge clk) begin
        if (rst) begin
            hold2 <= 1'b1;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (!ack_irq_en) begin
                hold2 <= 1'b1;
            end else if (data_end && ack_clk_en) begin
                hold2 <= 1'b0;
                irq   <= hold2;
            end else if (hold2_set_wr) begin
                hold2 <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !bus_en)
            stop_seen <= 1'b0;
        else if (ev.stop)
            stop_seen <= 1'b1;
        else if (stop_clr_wr)
            stop_seen <= 1'b0;
    end

    assign scl_hold = ~hold_n | ~hold2;
    assign status   = pack_status(flags, hold2, stop_seen);

    AST_STATUS_PAD: assert property (@(posedge clk) disable iff (rst)
        !status[3] && !status[4] && !status[6]); // R1
    AST_HOLD2_ACKOFF: assert property (@(posedge clk) disable iff (rst)
        !ack_irq_en |=> status[HOLD2_POS]); // R6
    AST_HOLD_WHEN_HOLD2: assert property (@(posedge clk) disable iff (rst)
        !status[HOLD2_POS] |-> scl_hold); // R7
    AST_STOP_BUSOFF: assert property (@(posedge clk) disable iff (rst)
        !bus_en |=> !status[STOP_POS]); // R8
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R9
    AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        irq |-> $fell(status[HOLD2_POS])); // R9

endmodule

// File: tb/sim_i2c_addr_status.sv
module sim_i2c_addr_status;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            scl = 1'b1;
    logic            sda = 1'b1;
    logic            bus_en = 1'b0;
    logic            match_en = 1'b0;
    logic            ten_bit = 1'b0;
    logic            ack_irq_en = 1'b0;
    logic            ack_clk_en = 1'b0;
    logic            hold_n = 1'b1;
    logic            data_wr = 1'b0;
    logic            stop_clr_wr = 1'b0;
    logic            hold2_set_wr = 1'b0;
    logic [2:0][7:0] slave_addr;
    logic [7:0]      status;
    logic            scl_hold;
    logic            irq;

    int ntests = 0;
    int nfails = 0;
    int irq_edges = 0;
    int irq_hi = 0;
    logic irq_q = 1'b0;

    typedef struct {
        logic [7:0] st;
        logic       hold;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    i2c_addr_status #(.SYNC_STAGES(3)) u0 (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda),
        .bus_en(bus_en), .match_en(match_en), .ten_bit(ten_bit),
        .ack_irq_en(ack_irq_en), .ack_clk_en(ack_clk_en), .hold_n(hold_n),
        .data_wr(data_wr), .stop_clr_wr(stop_clr_wr), .hold2_set_wr(hold2_set_wr),
        .slave_addr(slave_addr), .status(status), .scl_hold(scl_hold), .irq(irq)
    );

    // monitor: pop expected items and compare away from the active edge
    always @(negedge clk) begin
        exp_t e;
        if (sb.size() != 0) begin
            e = sb.pop_front();
            ntests++;
            if (status !== e.st || scl_hold !== e.hold) begin
                nfails++;
                $display("FAIL %s: status=%h scl_hold=%b expected status=%h scl_hold=%b",
                         e.tag, status, scl_hold, e.st, e.hold);
            end
        end
        if (irq) irq_hi++;
        if (irq && !irq_q) irq_edges++;
        irq_q = irq;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_st(input logic [7:0] st, input logic hold, input string tag);
        exp_t e;
        e.st = st; e.hold = hold; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_int(input int act, input int exp, input string tag);
        ntests++;
        if (act != exp) begin
            nfails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    localparam int PH = 10;

    task automatic bus_start();
        sda = 1'b1; tick(PH);
        scl = 1'b1; tick(PH);
        sda = 1'b0; tick(PH);
        scl = 1'b0; tick(PH);
    endtask

    task automatic bus_stop();
        sda = 1'b0; tick(PH);
        scl = 1'b1; tick(PH);
        sda = 1'b1; tick(PH);
    endtask

    task automatic bus_bit(input logic b);
        sda = b;    tick(PH);
        scl = 1'b1; tick(PH);
        scl = 1'b0; tick(PH);
    endtask

    task automatic bus_data8(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    endtask

    task automatic bus_byte(input logic [7:0] b);
        bus_data8(b);
        bus_bit(1'b1);
    endtask

    task automatic strobe_data_wr();
        data_wr = 1'b1; tick(1); data_wr = 1'b0; tick(2);
    endtask

    task automatic strobe_stop_clr();
        stop_clr_wr = 1'b1; tick(1); stop_clr_wr = 1'b0; tick(2);
    endtask

    task automatic strobe_hold2_set();
        hold2_set_wr = 1'b1; tick(1); hold2_set_wr = 1'b0; tick(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", ntests, nfails);
        $finish;
    end

    initial begin
        // slot0 0xA0, slot1 0x6E, slot2 0xA1: slots 0 and 2 share address 0x50
        slave_addr[0] = 8'hA0;
        slave_addr[1] = 8'h6E;
        slave_addr[2] = 8'hA1;
        tick(4);
        rst = 1'b0;
        tick(2);
        expect_st(8'h20, 1'b0, "R1 reset status");

        bus_en = 1'b1; match_en = 1'b1; ten_bit = 1'b0;
        tick(2);
        bus_start();
        bus_byte(8'hA1);
        expect_st(8'h25, 1'b0, "R2 7-bit match slots 0 and 2");
        bus_byte(8'h6E);
        expect_st(8'h25, 1'b0, "R4 second byte ignored");
        bus_stop();
        expect_st(8'hA5, 1'b0, "R8 stop flag set");
        strobe_stop_clr();
        expect_st(8'h25, 1'b0, "R8 stop clear strobe");
        strobe_data_wr();
        expect_st(8'h20, 1'b0, "R4 data write clears flags");

        ten_bit = 1'b1;
        bus_start();
        bus_byte(8'hA1);
        expect_st(8'h24, 1'b0, "R3 10-bit match slot 2 only");
        bus_start();
        bus_byte(8'hA0);
        expect_st(8'h21, 1'b0, "R10 repeated start recompares, R3 slot 0");

        match_en = 1'b0;
        tick(2);
        expect_st(8'h20, 1'b0, "R4 compare disable clears flags");
        bus_start();
        bus_byte(8'hA0);
        expect_st(8'h20, 1'b0, "R4 no match while disabled");
        bus_stop();
        expect_st(8'hA0, 1'b0, "R8 stop sets with compare disabled");
        bus_en = 1'b0;
        tick(2);
        expect_st(8'h20, 1'b0, "R8 bus disable clears stop flag");
        bus_en = 1'b1; match_en = 1'b1; ten_bit = 1'b0;
        ack_irq_en = 1'b1; ack_clk_en = 1'b1;
        tick(2);

        bus_start();
        bus_data8(8'h6E);
        expect_st(8'h02, 1'b1, "R5 hold2 drops after 8th bit, R7 hold");
        check_int(irq_edges, 1, "R9 one interrupt");
        strobe_hold2_set();
        expect_st(8'h22, 1'b0, "R6 set strobe releases hold2");
        bus_bit(1'b1);
        bus_stop();
        strobe_stop_clr();
        strobe_data_wr();
        expect_st(8'h20, 1'b0, "R8 R4 cleanup");

        ack_clk_en = 1'b0;
        tick(2);
        bus_start();
        bus_byte(8'hA0);
        expect_st(8'h25, 1'b0, "R5 no hold without ACK clock bit");
        check_int(irq_edges, 1, "R5 no interrupt without ACK clock bit");
        bus_stop();
        strobe_stop_clr();
        strobe_data_wr();

        ack_clk_en = 1'b1;
        tick(2);
        bus_start();
        bus_data8(8'h00);
        expect_st(8'h00, 1'b1, "R5 hold2 drops, no slot match");
        check_int(irq_edges, 2, "R9 second interrupt");
        ack_irq_en = 1'b0;
        tick(2);
        expect_st(8'h20, 1'b0, "R6 ACK interrupt disable releases hold2");
        bus_bit(1'b1);
        bus_stop();
        strobe_stop_clr();

        hold_n = 1'b0;
        tick(2);
        expect_st(8'h20, 1'b1, "R7 primary hold alone holds SCL");
        hold_n = 1'b1;
        tick(2);
        expect_st(8'h20, 1'b0, "R7 both released");

        check_int(irq_hi, irq_edges, "R9 interrupt lasts one cycle");

        tick(4);
        $display("  [TB] %0d tests run, %0d failed", ntests, nfails);
        $finish;
    end

endmodule